// File: doc/BRIEF.md
# Masked Program-Image Checksum Engine

This block folds a stream of 14-bit memory-image words into one 16-bit checksum. A stream opens with a start pulse and closes with a word that carries the last flag. Each word carries a two-bit kind tag that marks it as a program word, the first configuration word, the second configuration word or a user ID word. The masks for both configuration words and the number of program words to count come in on static inputs. They must stay steady for the length of a stream.

The block has two algorithms, and bit 6 of the first configuration word selects between them. When that bit is 1 the image is unprotected: the result is the sum of the program words plus each configuration word ANDed with its mask, and carries above bit 15 are dropped. When that bit is 0 the image is protected: the program words are accepted and then thrown away, and the low nibbles of the four user IDs are packed into one 16-bit term. The user ID that arrives first supplies the top nibble. That term is added to the masked configuration words. The same stream order therefore works for both modes, and the mode is decided only when the stream closes.

Top module: `cks_image_sum`

## Requirements
- R1: After reset, done_o is 0 and sum_o is 0.
- R2: Kind codes are 0 = program word, 1 = configuration word 1, 2 = configuration word 2, 3 = user ID. When bit 6 of configuration word 1 is 1, the result is the sum of the counted program words, plus (cfg1 & cfg1_mask_i), plus (cfg2 & cfg2_mask_i), taken modulo 2^16.
- R3: When bit 6 of configuration word 1 is 0, program words do not contribute. The result is (cfg1 & cfg1_mask_i) + (cfg2 & cfg2_mask_i) + the packed user ID term, modulo 2^16.
- R4: The packed user ID term is built from bits 3:0 of each user ID. The first user ID fills bits 15:12, the second bits 11:8, the third bits 7:4 and the fourth bits 3:0. Any user ID after the fourth is ignored, and a slot that receives no user ID is 0.
- R5: The mask inputs are applied when the result is formed. With cfg2_mask_i = 0003h, only bits 1:0 of configuration word 2 count.
- R6: Only the first prog_words_i program words of a stream are added. Later program words are ignored.
- R7: The mode follows configuration word 1 as received, wherever it falls in the stream. A stream without configuration word 1 or 2 uses 3FFFh for the missing word.
- R8: When a word with last_i = 1 is accepted at clock edge N, done_o is 1 for exactly the cycle after edge N+1, and sum_o holds the result from edge N+1 onward.
- R9: sum_o keeps its value until the next start_i. start_i clears sum_o to 0, clears done_o and abandons any stream in progress.
- R10: Words presented with valid_i while no stream is open have no effect on done_o or sum_o.
- R11: A word presented in the same cycle as start_i is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a new stream and clears the result |
| valid_i | input | 1 | Word on word_i is valid this cycle |
| last_i | input | 1 | Marks the final word of the stream |
| kind_i | input | 2 | Word kind: 0 program, 1 cfg1, 2 cfg2, 3 user ID |
| word_i | input | 14 | Image word |
| cfg1_mask_i | input | 14 | Mask for configuration word 1 |
| cfg2_mask_i | input | 14 | Mask for configuration word 2 |
| prog_words_i | input | 14 | Number of program words to sum |
| done_o | output | 1 | One-cycle completion pulse |
| sum_o | output | 16 | Checksum result |

## Verification
The bench uses a full blank 2K-word image. Its sum wraps far past 16 bits, so a design that kept the carries or limited the count wrongly would miss 2B8Eh. A protected stream that contains program words checks that those words are discarded. A stream where configuration word 1 arrives last checks that the mode is not fixed too early, and a design that decided the mode on arrival would report the unprotected sum instead. Other streams carry five user IDs with high bits set, extra program words beyond the count, a word sent together with start, a start that cuts a stream short, and idle words. A design that packed nibbles in reverse, let the fifth ID overwrite a slot, skipped the mask, or let stray words leak into the result gives a wrong sum or a spurious done.

// File: rtl/cks_pkg.sv
package cks_pkg;
    typedef enum logic [1:0] {
        WK_PROG = 2'd0,
        WK_CFG1 = 2'd1,
        WK_CFG2 = 2'd2,
        WK_UID  = 2'd3
    } word_kind_e;
endpackage

// File: rtl/cks_prog_acc.sv
// Sums program words up to a run-time count limit, modulo 2^SUM_W.
module cks_prog_acc #(
    parameter int WORD_W = 14,
    parameter int SUM_W  = 16,
    parameter int CNT_W  = 14
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              take_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [CNT_W-1:0]  limit_i,
    output logic [SUM_W-1:0]  sum_o
);
    typedef struct packed {
        logic [SUM_W-1:0] sum;
        logic [CNT_W-1:0] cnt;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.sum = '0;
            st_d.cnt = '0;
        end else if (take_i && (st_q.cnt < limit_i)) begin
            st_d.sum = st_q.sum + SUM_W'(word_i);
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sum_o = st_q.sum;
endmodule

// File: rtl/cks_uid_pack.sv
// Packs the low nibble of successive user IDs, first arrival on top.
module cks_uid_pack #(
    parameter int WORD_W = 14,
    parameter int NIB_W  = 4,
    parameter int UID_N  = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   clr_i,
    input  logic                   take_i,
    input  logic [WORD_W-1:0]      word_i,
    output logic [NIB_W*UID_N-1:0] packed_o
);
    localparam int IDX_W = $clog2(UID_N + 1);

    typedef struct packed {
        logic [IDX_W-1:0]            idx;
        logic [UID_N-1:0][NIB_W-1:0] nib;
    } pack_t;

    pack_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (take_i && (st_q.idx < IDX_W'(UID_N))) begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    // One slot per user ID; slot k sits at nibble UID_N-1-k.
    for (genvar k = 0; k < UID_N; k++) begin : g_slot
        logic [NIB_W-1:0] nib_d;
        always_comb begin
            nib_d = st_q.nib[UID_N-1-k];
            if (clr_i)
                nib_d = '0;
            else if (take_i && (st_q.idx == IDX_W'(k)))
                nib_d = word_i[NIB_W-1:0];
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) st_q.nib[UID_N-1-k] <= '0;
            else         st_q.nib[UID_N-1-k] <= nib_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q.idx <= '0;
        else         st_q.idx <= st_d.idx;
    end

    assign packed_o = st_q.nib;
endmodule

// File: rtl/cks_cfg_hold.sv
// Holds the two configuration words; blank value when never received.
module cks_cfg_hold #(
    parameter int WORD_W = 14
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              take1_i,
    input  logic              take2_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] cfg1_o,
    output logic [WORD_W-1:0] cfg2_o
);
    typedef struct packed {
        logic [WORD_W-1:0] c1;
        logic [WORD_W-1:0] c2;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.c1 = '1;
            st_d.c2 = '1;
        end else begin
            if (take1_i) st_d.c1 = word_i;
            if (take2_i) st_d.c2 = word_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '1;
        else         st_q <= st_d;
    end

    assign cfg1_o = st_q.c1;
    assign cfg2_o = st_q.c2;
endmodule

// File: rtl/cks_image_sum.sv
module cks_image_sum
    import cks_pkg::*;
#(
    parameter int WORD_W = 14,
    parameter int SUM_W  = 16,
    parameter int CNT_W  = 14,
    parameter int NIB_W  = 4,
    parameter int UID_N  = 4,
    parameter int CP_BIT = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              valid_i,
    input  logic              last_i,
    input  logic [1:0]        kind_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [WORD_W-1:0] cfg1_mask_i,
    input  logic [WORD_W-1:0] cfg2_mask_i,
    input  logic [CNT_W-1:0]  prog_words_i,
    output logic              done_o,
    output logic [SUM_W-1:0]  sum_o
);
    localparam int PACK_W = NIB_W * UID_N;

    typedef struct packed {
        logic             active;
        logic             pend;
        logic             done;
        logic [SUM_W-1:0] sum;
    } top_t;

    top_t st_d, st_q;

    logic              accept;
    word_kind_e        kind;
    logic [SUM_W-1:0]  prog_sum;
    logic [PACK_W-1:0] uid_term;
    logic [WORD_W-1:0] cfg1, cfg2;
    logic [SUM_W-1:0]  cfg_term;
    logic [SUM_W-1:0]  result;
    logic              prot;

    assign kind   = word_kind_e'(kind_i);
    assign accept = st_q.active && valid_i && !start_i;

    cks_prog_acc #(.WORD_W(WORD_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_prog (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (start_i),
        .take_i  (accept && (kind == WK_PROG)),
        .word_i  (word_i),
        .limit_i (prog_words_i),
        .sum_o   (prog_sum)
    );

    cks_uid_pack #(.WORD_W(WORD_W), .NIB_W(NIB_W), .UID_N(UID_N)) u_uid (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (start_i),
        .take_i   (accept && (kind == WK_UID)),
        .word_i   (word_i),
        .packed_o (uid_term)
    );

    cks_cfg_hold #(.WORD_W(WORD_W)) u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (start_i),
        .take1_i (accept && (kind == WK_CFG1)),
        .take2_i (accept && (kind == WK_CFG2)),
        .word_i  (word_i),
        .cfg1_o  (cfg1),
        .cfg2_o  (cfg2)
    );

    always_comb begin
        prot     = !cfg1[CP_BIT];
        cfg_term = SUM_W'(cfg1 & cfg1_mask_i) + SUM_W'(cfg2 & cfg2_mask_i);
        result   = cfg_term + (prot ? SUM_W'(uid_term) : prog_sum);
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.pend   = 1'b0;
            st_d.sum    = '0;
        end else begin
            if (accept && last_i) begin
                st_d.active = 1'b0;
                st_d.pend   = 1'b1;
            end
            if (st_q.pend) begin
                st_d.pend = 1'b0;
                st_d.done = 1'b1;
                st_d.sum  = result;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign sum_o  = st_q.sum;
endmodule

// File: rtl/cks_image_sum_chk.sv
module cks_image_sum_chk #(
    parameter int SUM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             valid,
    input logic             last,
    input logic             active,
    input logic             done,
    input logic [SUM_W-1:0] sum
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(valid && last && active && !start, 2)); // R8

    AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sum) |-> (done || $past(start))); // R9

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (sum == '0 && !done && active)); // R9

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> !active); // R10
endmodule

bind cks_image_sum cks_image_sum_chk #(.SUM_W(SUM_W)) u_chk (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .start  (start_i),
    .valid  (valid_i),
    .last   (last_i),
    .active (st_q.active),
    .done   (done_o),
    .sum    (sum_o)
);

// File: tb/tb_cks_image_sum.sv
`timescale 1ns/1ps
module tb_cks_image_sum;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        valid = 1'b0;
    logic        last = 1'b0;
    logic [1:0]  kind = 2'd0;
    logic [13:0] word = '0;
    logic [13:0] m1 = 14'h337B;
    logic [13:0] m2 = 14'h0013;
    logic [13:0] pw = 14'd2048;
    logic        done;
    logic [15:0] sum;

    int tests = 0;
    int fails = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    cks_image_sum dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .valid_i(valid),
        .last_i(last), .kind_i(kind), .word_i(word), .cfg1_mask_i(m1),
        .cfg2_mask_i(m2), .prog_words_i(pw), .done_o(done), .sum_o(sum)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic push(input logic [1:0] k, input logic [13:0] w, input logic l);
        valid = 1'b1; kind = k; word = w; last = l;
        @(negedge clk);
        valid = 1'b0; last = 1'b0;
    endtask

    // Called right after the last push: done shows one negedge later.
    task automatic expect_result(input string req, input logic [15:0] exp);
        @(negedge clk);
        check({req, " done high"}, 16'(done), 16'd1);
        check({req, " sum"}, sum, exp);
        @(negedge clk);
        check({req, " done low"}, 16'(done), 16'd0);
        check({req, " sum held"}, sum, exp);
    endtask

    task automatic t_reset();
        check("R1 done", 16'(done), 16'd0);
        check("R1 sum", sum, 16'h0000);
    endtask

    task automatic t_blank();   // R2 with wrap
        pw = 14'd2048; m1 = 14'h337B; m2 = 14'h0013;
        pulse_start();
        push(2'd1, 14'h3FFF, 1'b0);
        push(2'd2, 14'h3FFF, 1'b0);
        for (int i = 0; i < 2048; i++) push(2'd0, 14'h3FFF, i == 2047);
        expect_result("R2 blank", 16'h2B8E);
    endtask

    task automatic t_protected();   // R3 R4
        pw = 14'd100;
        pulse_start();
        push(2'd1, 14'h3FBF, 1'b0);
        push(2'd2, 14'h3FFF, 1'b0);
        for (int i = 0; i < 3; i++) push(2'd0, 14'h00AA, 1'b0);
        push(2'd3, 14'h0001, 1'b0);
        push(2'd3, 14'h0007, 1'b0);
        push(2'd3, 14'h000A, 1'b0);
        push(2'd3, 14'h000F, 1'b1);
        expect_result("R3 protected", 16'h4AFD);
    endtask

    task automatic t_order();   // R7, cfg1 last
        pw = 14'd8;
        pulse_start();
        for (int i = 0; i < 5; i++) push(2'd0, 14'h1234, 1'b0);
        push(2'd3, 14'h3FF5, 1'b0);
        push(2'd3, 14'h02A3, 1'b0);
        push(2'd2, 14'h3FFF, 1'b0);
        push(2'd1, 14'h3FBF, 1'b1);
        expect_result("R7 late cfg1", 16'h864E);
    endtask

    task automatic t_limit();   // R6
        pw = 14'd4;
        pulse_start();
        push(2'd0, 14'd1, 1'b0);
        push(2'd0, 14'd2, 1'b0);
        push(2'd0, 14'd3, 1'b0);
        push(2'd0, 14'd4, 1'b0);
        push(2'd0, 14'd100, 1'b0);
        push(2'd0, 14'd200, 1'b0);
        push(2'd1, 14'h3FFF, 1'b0);
        push(2'd2, 14'h0000, 1'b1);
        expect_result("R6 limit", 16'h3385);
    endtask

    task automatic t_uid_extra();   // R4 R5
        m2 = 14'h0003;
        pulse_start();
        push(2'd1, 14'h0000, 1'b0);
        push(2'd2, 14'h3FFF, 1'b0);
        push(2'd3, 14'h3FFC, 1'b0);
        push(2'd3, 14'h0011, 1'b0);
        push(2'd3, 14'h001E, 1'b0);
        push(2'd3, 14'h0007, 1'b0);
        push(2'd3, 14'h0009, 1'b1);
        expect_result("R4 fifth id", 16'hC1EA);
    endtask

    task automatic t_mask();   // R5
        pw = 14'd2; m1 = 14'h337B; m2 = 14'h0003;
        pulse_start();
        push(2'd0, 14'h00AA, 1'b0);
        push(2'd0, 14'h00AA, 1'b0);
        push(2'd1, 14'h3FFF, 1'b0);
        push(2'd2, 14'h3FFF, 1'b1);
        expect_result("R5 mask", 16'h34D2);
        m2 = 14'h0013;
    endtask

    task automatic t_idle();   // R10, sum from t_mask is 34D2
        push(2'd0, 14'h0100, 1'b0);
        push(2'd1, 14'h3FBF, 1'b1);
        push(2'd3, 14'h000F, 1'b1);
        for (int i = 0; i < 3; i++) begin
            check("R10 idle done", 16'(done), 16'd0);
            check("R10 idle sum", sum, 16'h34D2);
            @(negedge clk);
        end
    endtask

    task automatic t_restart();   // R9
        pw = 14'd10;
        pulse_start();
        push(2'd0, 14'h0777, 1'b0);
        push(2'd1, 14'h3FBF, 1'b0);
        pulse_start();
        check("R9 start clears", sum, 16'h0000);
        check("R9 start done", 16'(done), 16'd0);
        push(2'd1, 14'h3FFF, 1'b0);
        push(2'd2, 14'h3FFF, 1'b1);
        expect_result("R9 restart", 16'h338E);
    endtask

    task automatic t_start_with_word();   // R11
        valid = 1'b1; kind = 2'd0; word = 14'h0100; last = 1'b0;
        pulse_start();
        valid = 1'b0;
        push(2'd1, 14'h3FFF, 1'b0);
        push(2'd2, 14'h3FFF, 1'b1);
        expect_result("R11 start word", 16'h338E);
    endtask

    task automatic t_latency();   // R8
        pulse_start();
        push(2'd1, 14'h3FFF, 1'b0);
        valid = 1'b1; kind = 2'd2; word = 14'h3FFF; last = 1'b1;
        @(negedge clk);
        valid = 1'b0; last = 1'b0;
        check("R8 not yet", 16'(done), 16'd0);
        @(negedge clk);
        check("R8 done", 16'(done), 16'd1);
        @(negedge clk);
        check("R8 one cycle", 16'(done), 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_blank();
        t_protected();
        t_order();
        t_limit();
        t_uid_extra();
        t_mask();
        t_idle();
        t_restart();
        t_start_with_word();
        t_latency();
        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule